// File: doc/BRIEF.md
# Synchronous Dual-Port RAM Port Controller

This block is a two-port synchronous static RAM model. Both ports reach one shared word array and can read or write any location in the same cycle. Each port samples its address, controls and write data on the rising edge of the common clock `clk`. Each port has two chip selects of opposite polarity, an active-low write strobe, one active-low select per byte lane, an output enable that acts without a clock, and a static pin that selects whether read data passes through an extra output register.

Read data leaves each port on a separate output bus with one drive flag per byte lane, so no tristate pad is needed. A lane is driven only when its flag is high. Otherwise the lane's data bits are forced to zero. The default build has 1024 words of 18 bits, split into two 9-bit lanes. Width, depth, lane count and whether the output register is built are parameters.

Top module: `dpr_sync_dual`

## Requirements
- R1: A port is selected only when its `*_ce_n` is 0 and its `*_ce` is 1. A deselected port does not write the array and does not drive read data, whatever its write strobe is.
- R2: When a port is selected, `*_we_n`=0 writes the array and `*_we_n`=1 reads it. A write cycle does not drive read data.
- R3: With `*_pipe`=0 (flow-through), data for the address sampled at edge k is driven after edge k, before edge k+1.
- R4: With `*_pipe`=1 (pipelined), data for the address sampled at edge k is driven after edge k+1. Nothing from that read is driven between edge k and edge k+1.
- R5: In pipelined mode, a change of selection at edge k changes the drive state only after edge k+1. A deselect at edge k still lets the read from edge k-1 appear, and one selected read cycle is needed before output resumes.
- R6: Lane select bit 0 (`*_lane_n[0]`, active low) covers data bits 8:0 and bit 1 covers bits 17:9. A write leaves every deselected lane of the word unchanged.
- R7: Flag `*_rd_vld[i]` is high only if lane i was selected in the cycle that produced the data. Every lane whose flag is low reads as zero.
- R8: `*_oe_n`=1 clears all drive flags and zeroes the data at once, with no clock edge. Returning it to 0 restores the pending data in the same cycle.
- R9: A read on one port in the same cycle as a write to the same address on the other port returns the old word. The new word is returned from the next cycle on.
- R10: If both ports write the same address in the same cycle, the word from the right port is stored.
- R11: While `rst_n` is 0, every drive flag is low and all read data is zero, starting the moment reset is asserted. Reset does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; both ports sample on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read-output state |
| l_ce_n | input | 1 | Left chip select, active low |
| l_ce | input | 1 | Left chip select, active high |
| l_we_n | input | 1 | Left write strobe, active low |
| l_lane_n | input | LANES | Left byte-lane selects, active low |
| l_oe_n | input | 1 | Left output enable, active low, unclocked |
| l_pipe | input | 1 | Left mode: 0 flow-through, 1 pipelined |
| l_addr | input | ADDR_W | Left word address |
| l_wd | input | DATA_W | Left write data |
| l_rd | output | DATA_W | Left read data, zero in undriven lanes |
| l_rd_vld | output | LANES | Left per-lane drive flags |
| r_ce_n | input | 1 | Right chip select, active low |
| r_ce | input | 1 | Right chip select, active high |
| r_we_n | input | 1 | Right write strobe, active low |
| r_lane_n | input | LANES | Right byte-lane selects, active low |
| r_oe_n | input | 1 | Right output enable, active low, unclocked |
| r_pipe | input | 1 | Right mode: 0 flow-through, 1 pipelined |
| r_addr | input | ADDR_W | Right word address |
| r_wd | input | DATA_W | Right write data |
| r_rd | output | DATA_W | Right read data, zero in undriven lanes |
| r_rd_vld | output | LANES | Right per-lane drive flags |

## Verification
The left port runs flow-through and the right port runs pipelined, so one vector table shows both latencies side by side. Reads that cross ports at different addresses show that the ports are independent. Reads that cross ports at the same address, with a write on the other port, show whether old or new data is returned. A write to one address from both ports at once shows which port wins. Partial-lane reads and writes separate correct lane masking from whole-word behaviour. A deselect using each chip select in turn, including one made while a pipelined read is still in flight, shows the one-cycle lag of selection changes. Directed cases cover a write attempted while deselected, the output enable toggled between edges, and reset asserted during an active read.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

   // A port is live only with its low-true select low and high-true select high
   function automatic logic port_selected(input logic ce_n, input logic ce);
      return !ce_n && ce;
   endfunction

endpackage

// File: rtl/dpr_store.sv
`timescale 1ns/1ps
module dpr_store #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 18,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              l_wr,
   input  logic [LANES-1:0]  l_wlane,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wd,
   output logic [DATA_W-1:0] l_aq,
   input  logic              r_wr,
   input  logic [LANES-1:0]  r_wlane,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wd,
   output logic [DATA_W-1:0] r_aq
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int LANE_W = DATA_W / LANES;

   logic [DATA_W-1:0] mem [DEPTH];

   // Reads use the word from before this edge's writes; the right port's
   // write is applied last, so it wins when both ports hit one lane
   always_ff @(posedge clk) begin
      l_aq <= mem[l_addr];
      r_aq <= mem[r_addr];
      for (int i = 0; i < LANES; i++) begin
         if (l_wr && l_wlane[i])
            mem[l_addr][i*LANE_W +: LANE_W] <= l_wd[i*LANE_W +: LANE_W];
         if (r_wr && r_wlane[i])
            mem[r_addr][i*LANE_W +: LANE_W] <= r_wd[i*LANE_W +: LANE_W];
      end
   end
endmodule

// File: rtl/dpr_read_path.sv
`timescale 1ns/1ps
module dpr_read_path #(
   parameter int DATA_W   = 18,
   parameter int LANES    = 2,
   parameter bit HAS_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [LANES-1:0]  lane_n,
   input  logic              oe_n,
   input  logic              pipe,
   input  logic [DATA_W-1:0] arr_q,
   output logic [DATA_W-1:0] q,
   output logic [LANES-1:0]  q_vld
);
   localparam int LANE_W = DATA_W / LANES;

   logic              s1_vld;
   logic [LANES-1:0]  s1_lane_n;
   logic              cur_vld;
   logic [LANES-1:0]  cur_lane_n;
   logic [DATA_W-1:0] cur_dat;

   // Stage aligned with the array's read register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld    <= 1'b0;
         s1_lane_n <= '1;
      end else begin
         s1_vld    <= rd_req;
         s1_lane_n <= lane_n;
      end
   end

   generate
      if (HAS_PIPE) begin : g_pipe
         logic              s2_vld;
         logic [LANES-1:0]  s2_lane_n;
         logic [DATA_W-1:0] s2_dat;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s2_vld    <= 1'b0;
               s2_lane_n <= '1;
            end else begin
               s2_vld    <= s1_vld;
               s2_lane_n <= s1_lane_n;
            end
         end

         always_ff @(posedge clk) s2_dat <= arr_q;

         always_comb begin
            cur_vld    = pipe ? s2_vld    : s1_vld;
            cur_lane_n = pipe ? s2_lane_n : s1_lane_n;
            cur_dat    = pipe ? s2_dat    : arr_q;
         end
      end else begin : g_flow
         always_comb begin
            cur_vld    = s1_vld;
            cur_lane_n = s1_lane_n;
            cur_dat    = arr_q;
         end
      end

      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign q_vld[g] = cur_vld && !oe_n && !cur_lane_n[g];
         assign q[g*LANE_W +: LANE_W] = q_vld[g] ? cur_dat[g*LANE_W +: LANE_W] : '0;
      end
   endgenerate
endmodule

// File: rtl/dpr_sync_dual.sv
`timescale 1ns/1ps
module dpr_sync_dual #(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 18,
   parameter int LANES    = 2,
   parameter bit PIPE_OPT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_ce_n,
   input  logic              l_ce,
   input  logic              l_we_n,
   input  logic [LANES-1:0]  l_lane_n,
   input  logic              l_oe_n,
   input  logic              l_pipe,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wd,
   output logic [DATA_W-1:0] l_rd,
   output logic [LANES-1:0]  l_rd_vld,
   input  logic              r_ce_n,
   input  logic              r_ce,
   input  logic              r_we_n,
   input  logic [LANES-1:0]  r_lane_n,
   input  logic              r_oe_n,
   input  logic              r_pipe,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wd,
   output logic [DATA_W-1:0] r_rd,
   output logic [LANES-1:0]  r_rd_vld
);
   import dpr_pkg::*;

   generate
      if (LANES < 1 || DATA_W % LANES != 0) begin : g_bad_lanes
         $error("DATA_W must split evenly into LANES lanes");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W out of supported range");
      end
   endgenerate

   logic              l_sel, l_wr, l_rd_req;
   logic              r_sel, r_wr, r_rd_req;
   logic [DATA_W-1:0] l_aq, r_aq;

   always_comb begin
      l_sel    = port_selected(l_ce_n, l_ce);
      r_sel    = port_selected(r_ce_n, r_ce);
      l_wr     = l_sel && !l_we_n;
      r_wr     = r_sel && !r_we_n;
      l_rd_req = l_sel &&  l_we_n;
      r_rd_req = r_sel &&  r_we_n;
   end

   dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_store (
      .clk     (clk),
      .l_wr    (l_wr),
      .l_wlane (~l_lane_n),
      .l_addr  (l_addr),
      .l_wd    (l_wd),
      .l_aq    (l_aq),
      .r_wr    (r_wr),
      .r_wlane (~r_lane_n),
      .r_addr  (r_addr),
      .r_wd    (r_wd),
      .r_aq    (r_aq)
   );

   dpr_read_path #(.DATA_W(DATA_W), .LANES(LANES), .HAS_PIPE(PIPE_OPT)) i_rp_l (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_req (l_rd_req),
      .lane_n (l_lane_n),
      .oe_n   (l_oe_n),
      .pipe   (l_pipe),
      .arr_q  (l_aq),
      .q      (l_rd),
      .q_vld  (l_rd_vld)
   );

   dpr_read_path #(.DATA_W(DATA_W), .LANES(LANES), .HAS_PIPE(PIPE_OPT)) i_rp_r (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_req (r_rd_req),
      .lane_n (r_lane_n),
      .oe_n   (r_oe_n),
      .pipe   (r_pipe),
      .arr_q  (r_aq),
      .q      (r_rd),
      .q_vld  (r_rd_vld)
   );
endmodule

// File: rtl/dpr_port_chk.sv
`timescale 1ns/1ps
module dpr_port_chk #(
   parameter int DATA_W   = 18,
   parameter int LANES    = 2,
   parameter bit HAS_PIPE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              ce,
   input logic              we_n,
   input logic [LANES-1:0]  lane_n,
   input logic              oe_n,
   input logic              pipe,
   input logic [DATA_W-1:0] q,
   input logic [LANES-1:0]  q_vld
);
   localparam int LANE_W = DATA_W / LANES;

   logic sel, ppl;
   assign sel = !ce_n && ce;
   assign ppl = HAS_PIPE && pipe;

   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel ##1 !ppl |-> q_vld == '0); // R1
   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !we_n) ##1 !ppl |-> q_vld == '0); // R2
   AST_FLOW_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && we_n && lane_n == '0) ##1 (!ppl && !oe_n) |-> q_vld == '1); // R3
   AST_PIPE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && we_n && lane_n == '0) ##1 ppl ##1 (ppl && !oe_n) |-> q_vld == '1); // R4
   AST_PIPE_DESEL_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      !sel ##1 ppl |=> q_vld == '0); // R5
   AST_OE_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> q_vld == '0); // R8

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      AST_LANE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
         lane_n[g] ##1 !ppl |-> !q_vld[g]); // R7
      AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !q_vld[g] |-> q[g*LANE_W +: LANE_W] == '0); // R7
   end
endmodule

bind dpr_sync_dual dpr_port_chk #(.DATA_W(DATA_W), .LANES(LANES), .HAS_PIPE(PIPE_OPT)) u_chk_l (
   .clk(clk), .rst_n(rst_n), .ce_n(l_ce_n), .ce(l_ce), .we_n(l_we_n), .lane_n(l_lane_n),
   .oe_n(l_oe_n), .pipe(l_pipe), .q(l_rd), .q_vld(l_rd_vld));

bind dpr_sync_dual dpr_port_chk #(.DATA_W(DATA_W), .LANES(LANES), .HAS_PIPE(PIPE_OPT)) u_chk_r (
   .clk(clk), .rst_n(rst_n), .ce_n(r_ce_n), .ce(r_ce), .we_n(r_we_n), .lane_n(r_lane_n),
   .oe_n(r_oe_n), .pipe(r_pipe), .q(r_rd), .q_vld(r_rd_vld));

// File: tb/test_dpr_sync_dual.sv
`timescale 1ns/1ps
module test_dpr_sync_dual;
   localparam int AW = 10;
   localparam int DW = 18;
   localparam int LN = 2;

   localparam logic [1:0] OP_IDLE = 2'd0; // ce_n high
   localparam logic [1:0] OP_RD   = 2'd1;
   localparam logic [1:0] OP_WR   = 2'd2;
   localparam logic [1:0] OP_OFF  = 2'd3; // ce low

   typedef struct packed {
      logic [1:0]  lop;  logic [9:0] la; logic [17:0] ld; logic [1:0] lln;
      logic [1:0]  rop;  logic [9:0] ra; logic [17:0] rd; logic [1:0] rln;
      logic [17:0] el;   logic [1:0] elv;
      logic [17:0] er;   logic [1:0] erv;
   } vec_t;

   // Left runs flow-through (result of this row), right pipelined (result of previous row)
   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      '{OP_WR,  10'd5, 18'h12345, 2'b00, OP_WR,  10'd6, 18'h0ABCD, 2'b00, 18'h0,     2'b00, 18'h0,     2'b00}, // R2
      '{OP_RD,  10'd6, 18'h0,     2'b00, OP_RD,  10'd5, 18'h0,     2'b00, 18'h0ABCD, 2'b11, 18'h0,     2'b00}, // R3 R2
      '{OP_RD,  10'd5, 18'h0,     2'b01, OP_RD,  10'd6, 18'h0,     2'b00, 18'h12200, 2'b10, 18'h12345, 2'b11}, // R7 R4
      '{OP_WR,  10'd6, 18'h3FFFF, 2'b10, OP_RD,  10'd6, 18'h0,     2'b00, 18'h0,     2'b00, 18'h0ABCD, 2'b11}, // R6 R9
      '{OP_RD,  10'd6, 18'h0,     2'b00, OP_OFF, 10'd6, 18'h0,     2'b00, 18'h0ABFF, 2'b11, 18'h0ABCD, 2'b11}, // R6 R9 R5
      '{OP_IDLE,10'd6, 18'h0,     2'b00, OP_RD,  10'd6, 18'h0,     2'b00, 18'h0,     2'b00, 18'h0,     2'b00}, // R1 R5
      '{OP_WR,  10'd7, 18'h11111, 2'b00, OP_WR,  10'd7, 18'h22222, 2'b00, 18'h0,     2'b00, 18'h0ABFF, 2'b11}, // R10 R5
      '{OP_RD,  10'd7, 18'h0,     2'b00, OP_RD,  10'd7, 18'h0,     2'b10, 18'h22222, 2'b11, 18'h0,     2'b00}, // R10
      '{OP_IDLE,10'd0, 18'h0,     2'b00, OP_IDLE,10'd0, 18'h0,     2'b00, 18'h0,     2'b00, 18'h00022, 2'b01}, // R7
      '{OP_RD,  10'd5, 18'h0,     2'b00, OP_IDLE,10'd0, 18'h0,     2'b00, 18'h12345, 2'b11, 18'h0,     2'b00}, // R3
      '{OP_RD,  10'd5, 18'h0,     2'b00, OP_WR,  10'd5, 18'h00001, 2'b00, 18'h12345, 2'b11, 18'h0,     2'b00}, // R9
      '{OP_RD,  10'd5, 18'h0,     2'b00, OP_IDLE,10'd0, 18'h0,     2'b00, 18'h00001, 2'b11, 18'h0,     2'b00}  // R9
   };

   logic          clk, rst_n;
   logic          l_ce_n, l_ce, l_we_n, l_oe_n, l_pipe;
   logic [LN-1:0] l_lane_n, l_rd_vld;
   logic [AW-1:0] l_addr;
   logic [DW-1:0] l_wd, l_rd;
   logic          r_ce_n, r_ce, r_we_n, r_oe_n, r_pipe;
   logic [LN-1:0] r_lane_n, r_rd_vld;
   logic [AW-1:0] r_addr;
   logic [DW-1:0] r_wd, r_rd;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   dpr_sync_dual #(.ADDR_W(AW), .DATA_W(DW), .LANES(LN)) i_dpr_sync_dual (
      .clk(clk), .rst_n(rst_n),
      .l_ce_n(l_ce_n), .l_ce(l_ce), .l_we_n(l_we_n), .l_lane_n(l_lane_n), .l_oe_n(l_oe_n),
      .l_pipe(l_pipe), .l_addr(l_addr), .l_wd(l_wd), .l_rd(l_rd), .l_rd_vld(l_rd_vld),
      .r_ce_n(r_ce_n), .r_ce(r_ce), .r_we_n(r_we_n), .r_lane_n(r_lane_n), .r_oe_n(r_oe_n),
      .r_pipe(r_pipe), .r_addr(r_addr), .r_wd(r_wd), .r_rd(r_rd), .r_rd_vld(r_rd_vld));

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step;
      @(posedge clk);
      #2;
   endtask

   task automatic set_l(input logic [1:0] op, input logic [9:0] a, input logic [17:0] d,
                        input logic [1:0] ln);
      l_ce_n = (op == OP_IDLE); l_ce = (op != OP_OFF); l_we_n = (op != OP_WR);
      l_addr = a; l_wd = d; l_lane_n = ln;
   endtask

   task automatic set_r(input logic [1:0] op, input logic [9:0] a, input logic [17:0] d,
                        input logic [1:0] ln);
      r_ce_n = (op == OP_IDLE); r_ce = (op != OP_OFF); r_we_n = (op != OP_WR);
      r_addr = a; r_wd = d; r_lane_n = ln;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      l_oe_n = 1'b0; r_oe_n = 1'b0; l_pipe = 1'b0; r_pipe = 1'b1;
      set_l(OP_RD, 10'd0, 18'h0, 2'b00);
      set_r(OP_RD, 10'd0, 18'h0, 2'b00);
      repeat (3) @(posedge clk);
      #2;
      // R11: held in reset with reads requested
      chk("R11 left flags in reset", 32'(l_rd_vld), 32'(2'b00));
      chk("R11 left data in reset",  32'(l_rd),     32'(18'h0));
      chk("R11 right flags in reset", 32'(r_rd_vld), 32'(2'b00));
      set_l(OP_IDLE, 10'd0, 18'h0, 2'b00);
      set_r(OP_IDLE, 10'd0, 18'h0, 2'b00);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         set_l(VT[i].lop, VT[i].la, VT[i].ld, VT[i].lln);
         set_r(VT[i].rop, VT[i].ra, VT[i].rd, VT[i].rln);
         step();
         chk($sformatf("R3/R6/R9/R10 row %0d left data", i),  32'(l_rd),     32'(VT[i].el));
         chk($sformatf("R2/R7 row %0d left flags", i),        32'(l_rd_vld), 32'(VT[i].elv));
         chk($sformatf("R4/R5/R9 row %0d right data", i),     32'(r_rd),     32'(VT[i].er));
         chk($sformatf("R4/R5/R7 row %0d right flags", i),    32'(r_rd_vld), 32'(VT[i].erv));
      end

      // R1: writes attempted while deselected by either chip select
      set_l(OP_WR, 10'd9, 18'h15555, 2'b00);
      set_r(OP_IDLE, 10'd0, 18'h0, 2'b00);
      step();
      chk("R2 left write cycle not driven", 32'(l_rd_vld), 32'(2'b00));
      set_l(OP_OFF, 10'd9, 18'h2AAAA, 2'b00); l_we_n = 1'b0;
      set_r(OP_IDLE, 10'd9, 18'h3FFFF, 2'b00); r_we_n = 1'b0;
      step();
      chk("R1 deselected left not driven", 32'(l_rd_vld), 32'(2'b00));
      set_l(OP_RD, 10'd9, 18'h0, 2'b00);
      set_r(OP_IDLE, 10'd0, 18'h0, 2'b00);
      step();
      chk("R1 word kept after deselected writes", 32'(l_rd), 32'(18'h15555));
      chk("R3 flow read flags", 32'(l_rd_vld), 32'(2'b11));

      // R8: output enable acts between edges
      #1 l_oe_n = 1'b1;
      #1;
      chk("R8 oe high clears flags", 32'(l_rd_vld), 32'(2'b00));
      chk("R8 oe high zeroes data",  32'(l_rd),     32'(18'h0));
      l_oe_n = 1'b0;
      #1;
      chk("R8 oe low restores data", 32'(l_rd), 32'(18'h15555));

      // R4: pipelined port needs a second edge
      step();
      set_l(OP_IDLE, 10'd0, 18'h0, 2'b00);
      set_r(OP_RD, 10'd9, 18'h0, 2'b00);
      step();
      chk("R4 nothing after first edge", 32'(r_rd_vld), 32'(2'b00));
      set_r(OP_IDLE, 10'd0, 18'h0, 2'b00);
      step();
      chk("R4 data after second edge", 32'(r_rd), 32'(18'h15555));
      chk("R4 flags after second edge", 32'(r_rd_vld), 32'(2'b11));

      // R11: reset asserted in the middle of an active read
      set_l(OP_RD, 10'd9, 18'h0, 2'b00);
      step();
      chk("R3 read before reset", 32'(l_rd_vld), 32'(2'b11));
      #1 rst_n = 1'b0;
      #1;
      chk("R11 async reset clears flags", 32'(l_rd_vld), 32'(2'b00));
      chk("R11 async reset zeroes data",  32'(l_rd),     32'(18'h0));
      step();
      rst_n = 1'b1;
      step();
      chk("R11 array kept through reset", 32'(l_rd), 32'(18'h15555));

      finish_run();
   end
endmodule